// File: doc/BRIEF.md
# Circular Address Stepper

This block holds one DMA channel address and works out the next one after every completed transfer. The channel controller loads a starting address through a write port. It then pulses a one-cycle advance strobe each time a read or write beat finishes. On each strobe the stored address moves forward by the width of the beat: 1, 2 or 4 bytes.

A 4-bit wrap code can confine the low address bits to a power-of-two window, from 16 bytes up to 256 KB, so the channel can walk a circular buffer. The bits above the window keep the value they had in the register. A channel uses two instances, one for the source side and one for the destination side. The stepping can be switched off, and an align override forces it back on. A reserved width code is flagged as a configuration error and freezes the address.

Top module: `circ_addr_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `addr_out` is 0.
- R2: When `load_en` is high at a clock edge, `addr_out` takes `load_addr` at that edge, and a load wins over a simultaneous `advance`.
- R3: On an accepted advance, the address grows by the beat width selected by `size_code`: 0 selects 4 bytes, 1 selects 1 byte and 2 selects 2 bytes.
- R4: With `inc_en` and `align_en` both low, an `advance` strobe leaves `addr_out` unchanged.
- R5: With `align_en` high, an `advance` strobe steps the address even when `inc_en` is low.
- R6: With `wrap_code` 0, the step is a plain 32-bit addition that rolls over modulo 2^32.
- R7: With `wrap_code` n in the range 1 to 15, only the low n+3 address bits take the sum, so they wrap inside a window of 2^(n+3) bytes. The bits above the window keep their previous value.
- R8: A buffer whose start address is not aligned to the window wraps at the window boundary, not back to its start address.
- R9: `size_code` 3 is reserved. While it is applied, `cfg_err` is high and an `advance` leaves the address unchanged. For codes 0 to 2, `cfg_err` is low.
- R10: Without `load_en` or `advance`, `addr_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write strobe for the address register |
| load_addr | input | 32 | Value to write into the address register |
| advance | input | 1 | One-cycle strobe: a transfer beat has finished |
| size_code | input | 2 | Beat width: 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes, 3 = reserved |
| inc_en | input | 1 | Step the address on each advance |
| align_en | input | 1 | Force stepping even when inc_en is low |
| wrap_code | input | 4 | 0 = no wrap, n = wrap inside 2^(n+3) bytes |
| addr_out | output | 32 | Current address |
| cfg_err | output | 1 | Reserved beat-width code is applied |

## Verification
Each beat width is applied to the same start address, which separates the three step sizes from one another. Runs near the top of the address space tell the unwrapped 32-bit rollover apart from a windowed wrap. The smallest and largest windows are tried, and an unaligned start address shows that the wrap happens at the window edge rather than at the base. Strobes with stepping disabled, with the align override and with the reserved width separate the hold conditions from the forced advance.

// File: rtl/circ_addr_pkg.sv
// Shared types and sizes for the circular address stepper.
package circ_addr_pkg;
    localparam int ADDR_W  = 32;
    localparam int SIZE_W  = 2;
    localparam int WRAP_W  = 4;
    localparam int STEP_W  = 3;

    // Beat width encoding seen on size_code.
    typedef enum logic [SIZE_W-1:0] {
        BEAT_WORD = 2'd0,
        BEAT_BYTE = 2'd1,
        BEAT_HALF = 2'd2,
        BEAT_RSVD = 2'd3
    } beat_size_e;
endpackage

// File: rtl/cas_step_decode.sv
// Turns the beat-width code into a byte step and flags the reserved code.
// Assumes: code 3 is reserved; its step is forced to zero.
module cas_step_decode
    import circ_addr_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic [SW-1:0]     step,
    output logic              bad_code
);
    beat_size_e sz;
    assign sz = beat_size_e'(size_code);

    // Purpose: map the width code to a byte count.
    always_comb begin
        step     = '0;
        bad_code = 1'b0;
        case (sz)
            BEAT_WORD: step = SW'(4);
            BEAT_BYTE: step = SW'(1);
            BEAT_HALF: step = SW'(2);
            default:   bad_code = 1'b1;
        endcase
    end
endmodule

// File: rtl/cas_window_mask.sv
// Builds the mask of address bits that wrap for a given wrap code.
// Assumes: code 0 means no window; code n keeps n+MIN_LOG-1 low bits.
module cas_window_mask
    import circ_addr_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int CW      = WRAP_W,
    parameter int MIN_LOG = 4
) (
    input  logic [CW-1:0] wrap_code,
    output logic [AW-1:0] win_mask,
    output logic          wrap_on
);
    localparam int OFS = MIN_LOG - 1;

    assign wrap_on = (wrap_code != '0);

    // One compare per address bit: the bit is inside the window or not.
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign win_mask[i] = wrap_on && (i < (int'(wrap_code) + OFS));
    end
endmodule

// File: rtl/circ_addr_unit.sv
// Address register for one side of a DMA channel. It steps on each advance
// strobe and can wrap the low bits inside a power-of-two window.
// Assumes: advance is a single-cycle pulse and load_en takes priority.
module circ_addr_unit
    import circ_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              inc_en,
    input  logic              align_en,
    input  logic [WRAP_W-1:0] wrap_code,
    output logic [ADDR_W-1:0] addr_out,
    output logic              cfg_err
);
    logic [STEP_W-1:0] step;
    logic              bad_code;
    logic [ADDR_W-1:0] win_mask;
    logic              wrap_on;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] next_addr;
    logic              do_step;

    cas_step_decode #(.SW(STEP_W)) u_dec (
        .size_code (size_code),
        .step      (step),
        .bad_code  (bad_code)
    );

    cas_window_mask #(.AW(ADDR_W), .CW(WRAP_W), .MIN_LOG(4)) u_win (
        .wrap_code (wrap_code),
        .win_mask  (win_mask),
        .wrap_on   (wrap_on)
    );

    // Purpose: form the stepped address, merged with the held upper bits.
    always_comb begin
        sum = addr_q + ADDR_W'(step);
        if (wrap_on) next_addr = (addr_q & ~win_mask) | (sum & win_mask);
        else         next_addr = sum;
        do_step = advance && !bad_code && (inc_en || align_en);
    end

    // Purpose: the address register, with load over step.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (load_en) addr_q <= load_addr;
        else if (do_step) addr_q <= next_addr;
    end

    assign addr_out = addr_q;
    assign cfg_err  = bad_code;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> addr_q == $past(load_addr)); // R2
    AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !inc_en && !align_en && !load_en) |=> $stable(addr_q)); // R4
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap_on && !load_en) |=> ((addr_q ^ $past(addr_q)) & ~$past(win_mask)) == '0); // R7
    AST_RSVD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !load_en) |=> $stable(addr_q)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !advance) |=> $stable(addr_q)); // R10
    AST_ERR_CODE: assert property (@(posedge clk)
        cfg_err == (size_code == 2'd3)); // R9
endmodule

// File: tb/circ_addr_unit_test.sv
module circ_addr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_addr = '0;
    logic        advance = 1'b0;
    logic [1:0]  size_code = '0;
    logic        inc_en = 1'b0;
    logic        align_en = 1'b0;
    logic [3:0]  wrap_code = '0;
    logic [31:0] addr_out;
    logic        cfg_err;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    circ_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .advance(advance), .size_code(size_code), .inc_en(inc_en),
        .align_en(align_en), .wrap_code(wrap_code), .addr_out(addr_out),
        .cfg_err(cfg_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a);
        load_en = 1'b1; load_addr = a;
        tick();
        load_en = 1'b0;
    endtask

    task automatic step_once();
        advance = 1'b1;
        tick();
        advance = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", addr_out, 32'h0);
    endtask

    task automatic t_load();
        load(32'hDEAD_BEE0);
        check("R2", addr_out, 32'hDEAD_BEE0);
        inc_en = 1'b1; size_code = 2'd0;
        load_en = 1'b1; load_addr = 32'h0000_1000; advance = 1'b1;
        tick();
        load_en = 1'b0; advance = 1'b0;
        check("R2 priority", addr_out, 32'h0000_1000);
    endtask

    task automatic t_steps();
        inc_en = 1'b1; wrap_code = 4'd0;
        size_code = 2'd0; load(32'h100); step_once();
        check("R3 word", addr_out, 32'h104);
        size_code = 2'd1; load(32'h100); step_once();
        check("R3 byte", addr_out, 32'h101);
        size_code = 2'd2; load(32'h100); step_once(); step_once();
        check("R3 half", addr_out, 32'h104);
    endtask

    task automatic t_hold();
        inc_en = 1'b0; align_en = 1'b0; size_code = 2'd0;
        load(32'h200); step_once();
        check("R4", addr_out, 32'h200);
    endtask

    task automatic t_align();
        inc_en = 1'b0; align_en = 1'b1; size_code = 2'd2;
        load(32'h300); step_once();
        check("R5", addr_out, 32'h302);
        align_en = 1'b0;
    endtask

    task automatic t_nowrap();
        inc_en = 1'b1; wrap_code = 4'd0; size_code = 2'd0;
        load(32'hFFFF_FFFE); step_once();
        check("R6", addr_out, 32'h0000_0002);
    endtask

    task automatic t_wrap();
        inc_en = 1'b1; size_code = 2'd0; wrap_code = 4'd1;
        load(32'h1000_000C); step_once();
        check("R7 16B", addr_out, 32'h1000_0000);
        wrap_code = 4'd15; size_code = 2'd1;
        load(32'h1233_FFFF); step_once();
        check("R7 256K", addr_out, 32'h1230_0000);
        wrap_code = 4'd2; size_code = 2'd0;
        load(32'h4000_0010); step_once();
        check("R7 no edge", addr_out, 32'h4000_0014);
    endtask

    task automatic t_unaligned();
        inc_en = 1'b1; size_code = 2'd0; wrap_code = 4'd1;
        load(32'h2000_0008);
        step_once();
        check("R8 a", addr_out, 32'h2000_000C);
        step_once();
        check("R8 b", addr_out, 32'h2000_0000);
        step_once();
        check("R8 c", addr_out, 32'h2000_0004);
        wrap_code = 4'd0;
    endtask

    task automatic t_reserved();
        inc_en = 1'b1; size_code = 2'd3;
        load(32'h500);
        check("R9 err", {31'd0, cfg_err}, 32'd1);
        step_once();
        check("R9 hold", addr_out, 32'h500);
        size_code = 2'd1;
        @(posedge clk); @(negedge clk);
        check("R9 clear", {31'd0, cfg_err}, 32'd0);
    endtask

    task automatic t_idle();
        inc_en = 1'b1; size_code = 2'd0;
        load(32'h600);
        repeat (5) tick();
        check("R10", addr_out, 32'h600);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) tick();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_steps();
        t_hold();
        t_align();
        t_nowrap();
        t_wrap();
        t_unaligned();
        t_reserved();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule